// File: doc/BRIEF.md
# Event Counter Bank with Overflow Freeze

The block holds a small set of general-purpose event counters for processor performance monitoring. Each counter has its own configuration word and a data word. The configuration word chooses the event and enables the overflow interrupt. The data word holds the running count, and software may read it or preload it. There are two events. The first is the number of instructions retired in a cycle, given as a count from 0 to 2. The second is elapsed clock cycles. Counting only happens while the processor power-state input reports one of the two active states.

A carry out of a counter's top bit wraps that counter to zero and latches a sticky overflow status bit. If the counter's interrupt enable is set, the overflow also latches a global freeze bit and drives a level interrupt. The freeze halts every counter until software clears it. Software reaches the freeze bit, the status bits and all counter registers through one register port. Writes are single-cycle and reads are combinational.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter data word, every configuration word, the status word (address 0x1), the freeze bit (address 0x0, bit 0) and `irq` all read as zero.
- R2: Configuration bit 0 selects the event: 1 counts one per clock cycle, 0 adds the value of `retire_cnt` (0, 1 or 2). Counter i has its configuration word at address 8+2i and its data word at address 9+2i.
- R3: A counter advances only when `pwr_state` is 2'b00 (normal) or 2'b01 (low power). The codes 2'b10 and 2'b11 hold every counter.
- R4: A carry out of bit 31 wraps the counter modulo 2^32 and sets status bit i of counter i. This happens whatever the interrupt enable is set to.
- R5: An overflow of a counter whose configuration bit 1 (interrupt enable) is 1 also sets the freeze bit. A counter with the enable at 0 leaves the freeze bit alone.
- R6: While the freeze bit is 1, no counter advances. Only a software write clears the freeze bit. A software clear that lands in the same cycle as an enabled overflow leaves the bit at 1.
- R7: Status bits are sticky. A software write to the status word loads it. An overflow in the same cycle as that write still leaves its bit at 1.
- R8: Counters that overflow in the same cycle all set their status bits in that cycle.
- R9: A software write to a data word in the same cycle as an increment stores the written value. That increment raises no overflow.
- R10: Status bits 4 to 7 belong to unimplemented slots. They always read as zero, and writing ones to them has no effect.
- R11: `irq` is high exactly while some status bit is 1 and the interrupt enable of the same counter is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retire_cnt | input | 2 | Instructions retired this cycle (0 to 2) |
| pwr_state | input | 2 | Processor power state: 00 normal, 01 low power, 10 halt, 11 off |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level overflow interrupt |

## Verification
A faulty freeze or status flop shows at the ports within one cycle of an overflow. It shows as a wrong `irq` level, as a wrong freeze or status readback, or as a count of an unrelated counter that keeps moving when it should hold. A wrong carry or gating decision only shows as a data word that differs from the expected total, so every scenario runs a known number of cycles and then reads the count back. The corner cases where a write and an event arrive together are each run on the exact edge where they collide, and the result is read back on the next cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'b00,
    PWR_LOW    = 2'b01,
    PWR_HALT   = 2'b10,
    PWR_OFF    = 2'b11
  } pwr_e;

  typedef struct packed {
    logic oie;        // bit 1: overflow interrupt enable
    logic sel_cycles; // bit 0: 1 = cycles, 0 = retired instructions
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/pcb_event_gate.sv
module pcb_event_gate #(
  parameter int NUM_CTR = 4,
  parameter int INC_W   = 2
) (
  input  logic [1:0]                    pwr_state,
  input  logic                          freeze,
  input  logic [INC_W-1:0]              retire_cnt,
  input  logic [NUM_CTR-1:0]            sel_cycles,
  output logic [NUM_CTR-1:0][INC_W-1:0] inc
);
  import pcb_pkg::*;

  logic active;

  always_comb begin
    active = ((pwr_state == PWR_NORMAL) || (pwr_state == PWR_LOW)) && !freeze;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_sel
    always_comb begin
      if (!active)            inc[i] = '0;
      else if (sel_cycles[i]) inc[i] = INC_W'(1);
      else                    inc[i] = retire_cnt;
    end
  end

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CTR_W = 32,
  parameter int INC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              data_we,
  input  logic [CTR_W-1:0]  wdata,
  input  logic [INC_W-1:0]  inc,
  output pcb_pkg::cfg_t     cfg_q,
  output logic [CTR_W-1:0]  cnt_q,
  output logic              ovf_pulse
);
  import pcb_pkg::*;

  logic [CTR_W:0]   sum;
  logic [CTR_W-1:0] cnt_d;
  logic             cnt_en;
  cfg_t             cfg_d;

  always_comb begin
    sum       = {1'b0, cnt_q} + (CTR_W+1)'(inc);
    cnt_en    = data_we || (inc != '0);
    cnt_d     = data_we ? wdata : sum[CTR_W-1:0];
    ovf_pulse = !data_we && sum[CTR_W];
    cfg_d     = cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  // R9
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (cnt_q == $past(wdata)));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_we && inc == '0) |=> $stable(cnt_q));

  // R4
  wrap_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> (cnt_q < CTR_W'(2**INC_W)));

endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_we,
  input  logic               frz_we,
  input  logic [NUM_CTR-1:0] stat_wdata,
  input  logic               frz_wdata,
  input  logic [NUM_CTR-1:0] ovf_pulse,
  input  logic [NUM_CTR-1:0] oie,
  output logic [NUM_CTR-1:0] ovf_q,
  output logic               freeze_q,
  output logic               irq
);

  logic [NUM_CTR-1:0] ovf_d;
  logic               freeze_d;
  logic               frz_set;
  logic               ovf_en;
  logic               frz_en;

  always_comb begin
    frz_set  = |(ovf_pulse & oie);
    ovf_en   = stat_we || (ovf_pulse != '0);
    frz_en   = frz_we || frz_set;
    ovf_d    = (stat_we ? stat_wdata : ovf_q) | ovf_pulse;
    freeze_d = (frz_we ? frz_wdata : freeze_q) | frz_set;
    irq      = |(ovf_q & oie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else if (ovf_en) begin
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
    end else if (frz_en) begin
      freeze_q <= freeze_d;
    end
  end

  // R7
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R8
  all_overflows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse != '0) |=> ((ovf_q & $past(ovf_pulse)) == $past(ovf_pulse)));

  // R5
  freeze_on_enabled_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_pulse & oie)) |=> freeze_q);

  // R6
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !frz_we) |=> freeze_q);

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CTR   = 4,
  parameter int NUM_SLOTS = 8,
  parameter int CTR_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int INC_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  retire_cnt,
  input  logic [1:0]        pwr_state,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import pcb_pkg::*;

  localparam int                CTR_BASE = 2**(ADDR_W-1);
  localparam logic [ADDR_W-1:0] A_FREEZE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((64'd1 << NUM_CTR) - 64'd1);

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [NUM_CTR-1:0]            cfg_we;
  logic [NUM_CTR-1:0]            data_we;
  logic [NUM_CTR-1:0]            sel_cycles;
  logic [NUM_CTR-1:0]            oie;
  logic [NUM_CTR-1:0]            ovf_pulse;
  logic [NUM_CTR-1:0][INC_W-1:0] inc;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
  cfg_t [NUM_CTR-1:0]            cfg;
  logic [NUM_CTR-1:0]            ovf_q;
  logic                          freeze_q;
  logic                          stat_we;
  logic                          frz_we;
  logic [NUM_SLOTS-1:0]          slot_bits;

  always_comb begin
    stat_we = reg_wr && (reg_addr == A_STATUS);
    frz_we  = reg_wr && (reg_addr == A_FREEZE);
  end

  pcb_event_gate #(.NUM_CTR(NUM_CTR), .INC_W(INC_W)) u_gate (
    .pwr_state  (pwr_state),
    .freeze     (freeze_q),
    .retire_cnt (retire_cnt),
    .sel_cycles (sel_cycles),
    .inc        (inc)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_comb begin
      cfg_we[i]     = reg_wr && (reg_addr == ADDR_W'(CTR_BASE + 2*i));
      data_we[i]    = reg_wr && (reg_addr == ADDR_W'(CTR_BASE + 2*i + 1));
      sel_cycles[i] = cfg[i].sel_cycles;
      oie[i]        = cfg[i].oie;
    end

    pcb_counter #(.CTR_W(CTR_W), .INC_W(INC_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .cfg_we    (cfg_we[i]),
      .data_we   (data_we[i]),
      .wdata     (reg_wdata[CTR_W-1:0]),
      .inc       (inc[i]),
      .cfg_q     (cfg[i]),
      .cnt_q     (cnt[i]),
      .ovf_pulse (ovf_pulse[i])
    );
  end

  pcb_status #(.NUM_CTR(NUM_CTR)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .stat_we    (stat_we),
    .frz_we     (frz_we),
    .stat_wdata (reg_wdata[NUM_CTR-1:0]),
    .frz_wdata  (reg_wdata[0]),
    .ovf_pulse  (ovf_pulse),
    .oie        (oie),
    .ovf_q      (ovf_q),
    .freeze_q   (freeze_q),
    .irq        (irq)
  );

  always_comb begin
    slot_bits = NUM_SLOTS'(ovf_q);
    reg_rdata = '0;
    if (reg_addr == A_FREEZE) begin
      reg_rdata[0] = freeze_q;
    end else if (reg_addr == A_STATUS) begin
      reg_rdata[NUM_SLOTS-1:0] = slot_bits;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (reg_addr == ADDR_W'(CTR_BASE + 2*i))
          reg_rdata = DATA_W'(cfg[i]);
        if (reg_addr == ADDR_W'(CTR_BASE + 2*i + 1))
          reg_rdata = DATA_W'(cnt[i]);
      end
    end
  end

  // R10
  unimpl_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == A_STATUS) |-> ((reg_rdata & ~IMPL_MASK) == '0));

  // R11
  irq_follows_enabled_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|(ovf_pulse & oie) && !stat_we && !(|cfg_we)) |=> irq);

  // R6
  frozen_counters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (freeze_q && !(|data_we)) |=> $stable(cnt));

endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  retire_cnt;
  logic [1:0]  pwr_state;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks;
  int errors;
  bit done;

  localparam logic [1:0] P_NORM = 2'b00, P_LOW = 2'b01, P_HALT = 2'b10, P_OFF = 2'b11;
  localparam logic [3:0] A_FRZ = 4'h0, A_STAT = 4'h1;

  perf_counter_bank uut (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .pwr_state(pwr_state),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [3:0] cfg_a(int i);  return 4'(8 + 2*i); endfunction
  function automatic logic [3:0] data_a(int i); return 4'(9 + 2*i); endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(logic [1:0] p, int n);
    pwr_state = p;
    repeat (n) @(negedge clk);
    pwr_state = P_HALT;
  endtask

  task automatic clean();
    for (int i = 0; i < 4; i++) begin
      wr(cfg_a(i), 32'h0);
      wr(data_a(i), 32'h0);
    end
    wr(A_STAT, 32'h0);
    wr(A_FRZ, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_FRZ, v);  check("R1 freeze", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(cfg_a(i), v);  check("R1 cfg", v, 0);
      rd(data_a(i), v); check("R1 data", v, 0);
    end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    clean();
    wr(cfg_a(0), 32'h1);
    run(P_NORM, 7);
    rd(data_a(0), v); check("R2 cycle count", v, 7);
    // counter 1 on retire event
    pwr_state = P_NORM;
    retire_cnt = 2; @(negedge clk);
    retire_cnt = 1; @(negedge clk);
    retire_cnt = 0; @(negedge clk);
    retire_cnt = 2; @(negedge clk);
    retire_cnt = 0; pwr_state = P_HALT;
    rd(data_a(1), v); check("R2 retire sum", v, 5);
    rd(data_a(0), v); check("R2 cycles alongside", v, 11);
  endtask

  task automatic t_power();
    logic [31:0] v;
    clean();
    wr(cfg_a(0), 32'h1);
    run(P_HALT, 4);
    run(P_OFF, 4);
    rd(data_a(0), v); check("R3 gated states hold", v, 0);
    run(P_LOW, 3);
    rd(data_a(0), v); check("R3 low power counts", v, 3);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    clean();
    wr(cfg_a(0), 32'h3);
    wr(data_a(0), 32'hFFFF_FFFE);
    wr(cfg_a(1), 32'h1);
    wr(data_a(1), 32'd100);
    run(P_NORM, 5);
    rd(data_a(0), v); check("R4 wrap to zero", v, 0);
    rd(data_a(1), v); check("R6 other counter frozen", v, 102);
    rd(A_STAT, v);    check("R4 status bit0", v, 1);
    rd(A_FRZ, v);     check("R5 freeze set", v, 1);
    check("R11 irq high", 32'(irq), 1);
    run(P_NORM, 3);
    rd(data_a(1), v); check("R6 still frozen", v, 102);
    wr(A_STAT, 32'h0);
    check("R11 irq low after clear", 32'(irq), 0);
    rd(A_FRZ, v);     check("R6 freeze survives status clear", v, 1);
    wr(A_FRZ, 32'h0);
    run(P_NORM, 1);
    rd(data_a(1), v); check("R6 resumes after clear", v, 103);
  endtask

  task automatic t_no_oie();
    logic [31:0] v;
    clean();
    wr(cfg_a(1), 32'h1);
    wr(data_a(1), 32'hFFFF_FFFF);
    run(P_NORM, 2);
    rd(data_a(1), v); check("R4 wrap no oie", v, 1);
    rd(A_STAT, v);    check("R4 status bit1", v, 2);
    rd(A_FRZ, v);     check("R5 no freeze without oie", v, 0);
    check("R11 irq low without oie", 32'(irq), 0);
  endtask

  task automatic t_concurrent();
    logic [31:0] v;
    clean();
    wr(cfg_a(2), 32'h1); wr(data_a(2), 32'hFFFF_FFFF);
    wr(cfg_a(3), 32'h1); wr(data_a(3), 32'hFFFF_FFFF);
    run(P_NORM, 1);
    rd(A_STAT, v); check("R8 both bits", v, 32'hC);
  endtask

  task automatic t_retire_wrap();
    logic [31:0] v;
    clean();
    wr(data_a(0), 32'hFFFF_FFFF);
    pwr_state = P_NORM; retire_cnt = 2;
    @(negedge clk);
    retire_cnt = 0; pwr_state = P_HALT;
    rd(data_a(0), v); check("R2 retire wraps by two", v, 1);
    rd(A_STAT, v);    check("R4 retire overflow", v, 1);
  endtask

  task automatic t_write_prio();
    logic [31:0] v;
    clean();
    wr(cfg_a(0), 32'h3);
    wr(data_a(0), 32'hFFFF_FFFF);
    pwr_state = P_NORM;
    wr(data_a(0), 32'd7);
    pwr_state = P_HALT;
    rd(data_a(0), v); check("R9 write wins", v, 7);
    rd(A_STAT, v);    check("R9 no overflow", v, 0);
    rd(A_FRZ, v);     check("R9 no freeze", v, 0);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    clean();
    wr(A_STAT, 32'h2);
    wr(cfg_a(0), 32'h1);
    wr(data_a(0), 32'hFFFF_FFFF);
    pwr_state = P_NORM;
    wr(A_STAT, 32'h0);
    pwr_state = P_HALT;
    rd(A_STAT, v); check("R7 overflow beats clear", v, 1);
    clean();
    wr(cfg_a(0), 32'h3);
    wr(data_a(0), 32'hFFFF_FFFF);
    pwr_state = P_NORM;
    wr(A_FRZ, 32'h0);
    pwr_state = P_HALT;
    rd(A_FRZ, v); check("R6 overflow beats freeze clear", v, 1);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    clean();
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); check("R10 upper slots zero", v, 32'h0F);
    check("R11 irq low, no enables", 32'(irq), 0);
    wr(A_STAT, 32'hF0);
    rd(A_STAT, v); check("R10 write ignored", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; retire_cnt = 0; pwr_state = P_HALT;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_events();
    t_power();
    t_freeze();
    t_no_oie();
    t_concurrent();
    t_retire_wrap();
    t_write_prio();
    t_clear_race();
    t_unimpl();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule